// File: doc/BRIEF.md
# Bi-Endian Load Aligner

This block stands between a core's load port and a data memory that is organised as 32-bit words. It returns a byte, a halfword or a word that starts at any byte address. A mode input picks the byte order for each request: in little-endian order the lowest address holds the least significant byte, and in big-endian order it holds the most significant byte. Because the mode is captured when a request is accepted, software can switch the order between two loads.

An object that fits in one memory word needs a single memory read. An object that crosses a word boundary needs two reads, one at the word that holds the start byte and one at the following word. The bytes from the two reads are merged before the result is returned. The result can be zero-extended or sign-extended to 32 bits. Only one request is handled at a time, and a ready output tells the requester when a new request can be accepted.

Top module: `endian_load_unit`

## Requirements
- R1: While reset is held and in the first cycle after reset, `ready` is 1 and both `rsp_valid` and `mem_rd_en` are 0.
- R2: Memory lanes are fixed: the byte at address 4k+j sits in bits [8j+7:8j] of memory word k. In little-endian mode (`req_big`=0), the byte at the request address becomes the least significant byte of the result, and each higher address fills the next more significant byte.
- R3: In big-endian mode (`req_big`=1), the byte at the request address becomes the most significant byte of the object. For example, if the bytes 12,34,56,78 are stored at 0x10..0x13, a word load at 0x10 returns 0x12345678.
- R4: `req_size` selects 00 = byte, 01 = halfword, 10 = word. When `req_signed`=0, the unused upper bits of the result are zero.
- R5: When `req_signed`=1, the top bit of the object is copied into every unused upper bit of the result.
- R6: A request that lies within one word causes exactly one memory read, at word address `req_addr>>2`, issued in the acceptance cycle. `rsp_valid` is asserted two cycles after acceptance.
- R7: A request that crosses a word boundary (a halfword at offset 3, or a word at offset 1, 2 or 3) reads word `req_addr>>2` and then the next word address, which wraps modulo the memory size. `rsp_valid` is asserted three cycles after acceptance and is low in the cycle before that.
- R8: A request with size 11 causes no memory read. Two cycles after acceptance it responds with `rsp_err`=1 and `rsp_data`=0.
- R9: `ready` is low from the cycle after acceptance until the response cycle. A request presented while `ready` is low is ignored: it causes no read and does not change the response.
- R10: The byte order and the sign option are sampled at acceptance. Changing `req_big` after acceptance does not change the result.
- R11: `rsp_valid` is a one-cycle pulse, and `rsp_err` is 0 for every request of size 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| req_big | input | 1 | 1 selects big-endian order, 0 selects little-endian order |
| req_signed | input | 1 | 1 selects sign extension, 0 selects zero extension |
| ready | output | 1 | A request can be accepted in this cycle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW-2 | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Result valid (one-cycle pulse) |
| rsp_data | output | 32 | Extended load result |
| rsp_err | output | 1 | Illegal size was requested |

## Verification
The assertions assume that the memory returns data exactly one cycle after each strobe, and that request fields are meaningful only in a cycle where both `req_valid` and `ready` are high. The bench's memory model answers with a fixed one-cycle delay. The bench also changes the request fields only at falling edges. While the unit is busy, it deliberately holds up a different request and flips the byte order, so that the ignore and sampling rules are actually exercised rather than assumed.

// File: rtl/endian_load_unit.sv
module endian_load_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_big,
  input  logic          req_signed,
  output logic          ready,
  output logic          mem_rd_en,
  output logic [AW-3:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          rsp_err
);
  localparam int WAW = AW - 2;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t         st;
  logic [1:0]     off_q, size_q;
  logic           big_q, sgn_q, split_q, bad_q;
  logic [WAW-1:0] wa_q;
  logic [31:0]    lo_q;

  logic        accept, req_bad, req_split;
  logic [63:0] pair;
  logic [7:0]  b [4];
  logic [15:0] half;
  logic [31:0] shaped;

  assign ready     = (st == S_IDLE);
  assign accept    = req_valid && ready;
  assign req_bad   = (req_size == 2'b11);
  assign req_split = (req_size == 2'b01 && req_addr[1:0] == 2'b11) ||
                     (req_size == 2'b10 && req_addr[1:0] != 2'b00);

  assign mem_rd_en   = (accept && !req_bad) || (st == S_FIRST && split_q);
  assign mem_rd_addr = (st == S_FIRST) ? wa_q + WAW'(1) : req_addr[AW-1:2];

  assign pair = {mem_rd_data, (st == S_SECOND) ? lo_q : mem_rd_data};

  always_comb begin
    for (int i = 0; i < 4; i++)
      b[i] = pair[{{1'b0, off_q} + 3'(i), 3'b000} +: 8];
    half = big_q ? {b[0], b[1]} : {b[1], b[0]};
    case (size_q)
      2'b00:   shaped = {{24{sgn_q & b[0][7]}}, b[0]};
      2'b01:   shaped = {{16{sgn_q & half[15]}}, half};
      default: shaped = big_q ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      off_q     <= '0;
      size_q    <= '0;
      big_q     <= 1'b0;
      sgn_q     <= 1'b0;
      split_q   <= 1'b0;
      bad_q     <= 1'b0;
      wa_q      <= '0;
      lo_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          off_q   <= req_addr[1:0];
          size_q  <= req_size;
          big_q   <= req_big;
          sgn_q   <= req_signed;
          split_q <= req_split;
          bad_q   <= req_bad;
          wa_q    <= req_addr[AW-1:2];
          st      <= S_FIRST;
        end
        S_FIRST: begin
          lo_q <= mem_rd_data;
          if (split_q) begin
            st <= S_SECOND;
          end else begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= bad_q ? '0 : shaped;
            rsp_err   <= bad_q;
          end
        end
        default: begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_data  <= shaped;
          rsp_err   <= 1'b0;
        end
      endcase
    end
  end
endmodule

module endian_load_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic        ready,
  input logic        mem_rd_en,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        rsp_err
);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready);

  // R6
  legal_reads_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && req_size != 2'b11) |-> mem_rd_en);

  // R8
  illegal_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && req_size == 2'b11) |-> !mem_rd_en);

  // R8
  illegal_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && req_size == 2'b11) |-> ##2 (rsp_valid && rsp_err && rsp_data == 32'h0));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ready);
endmodule

bind endian_load_unit endian_load_chk u_chk (.*);

// File: tb/endian_load_unit_tb.sv
module endian_load_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic req_big = 1'b0, req_signed = 1'b0;
  logic ready, mem_rd_en, rsp_valid, rsp_err;
  logic [AW-3:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0, rsp_data;

  logic [31:0] mem [64];
  int rd_log [64];
  int rd_total = 0;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_load_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_big(req_big), .req_signed(req_signed),
    .ready(ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );

  always @(posedge clk) if (mem_rd_en) begin
    mem_rd_data <= mem[mem_rd_addr];
    rd_log[rd_total % 64] <= int'(mem_rd_addr);
    rd_total <= rd_total + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int a);
    int w = (a % 256) / 4;
    int l = a % 4;
    return mem[w][8*l +: 8];
  endfunction

  function automatic logic [31:0] ref_load(input int a, input logic [1:0] sz,
                                            input bit big, input bit sgn);
    logic [31:0] v = '0;
    int n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    if (sz == 2'b11) return '0;
    for (int i = 0; i < n; i++) begin
      if (big) v = (v << 8) | 32'(byte_at(a + i));
      else     v = v | (32'(byte_at(a + i)) << (8*i));
    end
    if (sgn && n < 4 && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8*n));
    return v;
  endfunction

  task automatic load(input int a, input logic [1:0] sz, input bit big,
                      input bit sgn, input string req);
    int base;
    int off = a % 4;
    bit bad = (sz == 2'b11);
    bit split = (sz == 2'b01 && off == 3) || (sz == 2'b10 && off != 0);
    int lat = split ? 3 : 2;
    logic [31:0] exp = ref_load(a, sz, big, sgn);
    @(negedge clk);
    base = rd_total;
    req_valid = 1'b1; req_addr = AW'(a); req_size = sz;
    req_big = big; req_signed = sgn;
    @(posedge clk); @(negedge clk);
    chk(ready == 1'b0, "R9", "ready after accept", 32'(ready), 32'h0);
    // R9 stray request while busy, R10 mode flipped after acceptance
    req_addr = AW'(a) ^ 8'h55; req_size = 2'b10; req_big = ~big; req_signed = ~sgn;
    for (int k = 2; k <= lat; k++) begin
      @(posedge clk); @(negedge clk);
      if (k < lat) chk(rsp_valid == 1'b0, "R7", "early rsp_valid", 32'(rsp_valid), 32'h0);
    end
    chk(rsp_valid == 1'b1, split ? "R7" : "R6", "rsp_valid latency", 32'(rsp_valid), 32'h1);
    chk(rsp_data == exp, req, "rsp_data", rsp_data, exp);
    chk(rsp_err == bad, bad ? "R8" : "R11", "rsp_err", 32'(rsp_err), 32'(bad));
    chk(rd_total - base == (bad ? 0 : split ? 2 : 1), bad ? "R8" : split ? "R7" : "R6",
        "read count", 32'(rd_total - base), 32'(bad ? 0 : split ? 2 : 1));
    if (!bad)
      chk(rd_log[base % 64] == (a % 256) / 4, "R6", "first read addr",
          32'(rd_log[base % 64]), 32'((a % 256) / 4));
    if (split)
      chk(rd_log[(base + 1) % 64] == ((a % 256) / 4 + 1) % 64, "R7", "second read addr",
          32'(rd_log[(base + 1) % 64]), 32'(((a % 256) / 4 + 1) % 64));
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "rsp pulse length", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready in reset", 32'(ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    chk(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset", 32'(mem_rd_en), 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset",
        {30'h0, ready, rsp_valid}, 32'h2);
  endtask

  task automatic t_little();
    load(16, 2'b10, 1'b0, 1'b0, "R2");
    load(16, 2'b01, 1'b0, 1'b0, "R2");
    load(18, 2'b01, 1'b0, 1'b0, "R4");
    load(17, 2'b00, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_big();
    load(16, 2'b10, 1'b1, 1'b0, "R3");
    chk(rsp_data == 32'h1234_5678, "R3", "word example", rsp_data, 32'h1234_5678);
    load(16, 2'b01, 1'b1, 1'b0, "R3");
    load(18, 2'b01, 1'b1, 1'b0, "R10");
  endtask

  task automatic t_sign();
    load(22, 2'b00, 1'b0, 1'b1, "R5");
    load(22, 2'b00, 1'b0, 1'b0, "R4");
    load(22, 2'b01, 1'b0, 1'b1, "R5");
    load(22, 2'b01, 1'b1, 1'b1, "R5");
    load(21, 2'b01, 1'b0, 1'b1, "R5");
    load(20, 2'b10, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_split();
    load(19, 2'b10, 1'b0, 1'b0, "R7");
    load(19, 2'b10, 1'b1, 1'b0, "R7");
    load(18, 2'b10, 1'b1, 1'b1, "R7");
    load(19, 2'b01, 1'b0, 1'b1, "R7");
    load(23, 2'b01, 1'b1, 1'b0, "R7");
    load(254, 2'b10, 1'b0, 1'b0, "R7");
    load(255, 2'b01, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_illegal();
    load(17, 2'b11, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    for (int k = 0; k < 64; k++)
      for (int j = 0; j < 4; j++)
        mem[k][8*j +: 8] = 8'((4*k + j) * 37 + 11);
    mem[4] = 32'h7856_3412;
    mem[5] = 32'h80FF_7F01;
    mem[63] = 32'hC3B2_A190;
    t_reset();
    t_little();
    t_big();
    t_sign();
    t_split();
    t_illegal();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R9 watchdog: actual %h expected %h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule